// File: doc/BRIEF.md
# Fractional UART Baud Tick Generator

This block derives the 16x-oversampling tick for a UART's transmit and receive bit timers from a fast reference clock. The reference is first divided by a prescaler whose ratio comes from a 3-bit code. Each prescaler strobe then adds the effective numerator to a phase accumulator. A tick is emitted whenever the accumulator reaches the effective denominator. Over time the tick rate equals reference / ratio × (numerator+1) / (denominator+1).

Software programs the block through a single write port with a 2-bit register select. A prescaler code applies at once. A numerator write is held in a shadow register, and it becomes active only when the very next write is a denominator write. That second write makes both values active together and restarts the accumulator, so the generator never runs on a half-updated fraction. The tick is suppressed, and its timing state cleared, while the UART enable input is low.

Top module: `baud_tick_gen`

## Requirements
- R1: While reset is high, tick is low. After reset the prescaler code is 5 (ratio 1), the numerator register is 15 (effective 16) and the denominator register is 0 (effective 1), so with enable high a tick follows on every clock.
- R2: A write with select 0 loads wr_data[2:0] as the prescaler code, with ratio 6,5,4,3,2,1,7,1 for codes 0 to 7. The new ratio applies from the next clock, and the prescaler count restarts at zero.
- R3: On each prescaler strobe the accumulator adds numerator+1. When the sum is at least denominator+1, a tick is produced and denominator+1 is subtracted. The long-run tick rate is reference/ratio × (num+1)/(den+1), and the accumulator stays below denominator+1.
- R4: tick is high for single clocks, at most once per prescaler strobe, one clock after that strobe. When numerator+1 is greater than or equal to denominator+1, every strobe produces a tick.
- R5: A write with select 1 stores wr_data+1 only in a shadow register. The active rate does not change.
- R6: A write with select 2 whose immediately preceding write was a select-1 write commits the shadow numerator and wr_data+1 as the denominator in the same clock, and clears the accumulator. Idle clocks between the two writes are allowed.
- R7: A select-2 write not directly preceded by a select-1 write is ignored. Any other write in between, including select 0 or the unused select 3, breaks the pairing.
- R8: While uart_en is low, tick stays low and the prescaler and accumulator are held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| uart_en | input | 1 | UART enable; low gates the tick off |
| wr_valid | input | 1 | Register write strobe |
| wr_sel | input | 2 | Target: 0 prescaler, 1 numerator, 2 denominator, 3 none |
| wr_data | input | DW | Write data (register value, i.e. effective minus one) |
| tick | output | 1 | Single-cycle 16x oversampling tick |

## Verification
The accumulator bound assumes a well-formed commit. A new denominator and the accumulator clear land on the same edge, so no stale remainder can exceed the new limit. The stimulus only changes the fraction through the write port, and the block itself enforces that ordering. The tick-needs-strobe property assumes that inputs change away from the clock edge. The bench drives every input on the falling edge, and it covers both fractions below one and fractions at or above one, where the clamp applies.

// File: rtl/baud_pkg.sv
package baud_pkg;

    typedef enum logic [1:0] {
        SEL_PRESCALE = 2'd0,
        SEL_NUMER    = 2'd1,
        SEL_DENOM    = 2'd2,
        SEL_UNUSED   = 2'd3
    } reg_sel_e;

    localparam int CODE_W = 3;

    // Terminal count (ratio minus one) of the prescaler for each code.
    function automatic logic [CODE_W-1:0] prescale_tc(input logic [CODE_W-1:0] code);
        logic [CODE_W-1:0] tc;
        case (code)
            3'd0:    tc = 3'd5;
            3'd1:    tc = 3'd4;
            3'd2:    tc = 3'd3;
            3'd3:    tc = 3'd2;
            3'd4:    tc = 3'd1;
            3'd6:    tc = 3'd6;
            default: tc = 3'd0;
        endcase
        return tc;
    endfunction

endpackage

// File: rtl/baud_cfg.sv
module baud_cfg
    import baud_pkg::*;
#(
    parameter int DW = 16,
    localparam int AW = DW + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  reg_sel_e          wr_sel,
    input  logic [DW-1:0]     wr_data,
    output logic [CODE_W-1:0] pre_code,
    output logic              pre_load,
    output logic              commit,
    output logic              armed,
    output logic [AW-1:0]     num_eff,
    output logic [AW-1:0]     den_eff
);
    logic          is_num, is_den;
    logic [AW-1:0] shadow;
    logic [AW-1:0] data_eff;

    assign pre_load = wr_valid && (wr_sel == SEL_PRESCALE);
    assign is_num   = wr_valid && (wr_sel == SEL_NUMER);
    assign is_den   = wr_valid && (wr_sel == SEL_DENOM);
    assign commit   = is_den && armed;
    assign data_eff = {1'b0, wr_data} + AW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_code <= 3'd5;
            shadow   <= AW'(16);
            num_eff  <= AW'(16);
            den_eff  <= AW'(1);
            armed    <= 1'b0;
        end else begin
            if (pre_load) pre_code <= wr_data[CODE_W-1:0];
            if (is_num)   shadow   <= data_eff;
            if (commit) begin
                num_eff <= shadow;
                den_eff <= data_eff;
            end
            if (wr_valid) armed <= is_num;
        end
    end
endmodule

// File: rtl/baud_prescale.sv
module baud_prescale
    import baud_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              restart,
    input  logic [CODE_W-1:0] code,
    output logic              strobe
);
    logic [CODE_W-1:0] cnt;
    logic [CODE_W-1:0] tc;

    assign tc     = prescale_tc(code);
    assign strobe = en && (cnt == tc);

    always_ff @(posedge clk) begin
        if (rst || !en || restart || strobe) cnt <= '0;
        else                                 cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/baud_accum.sv
module baud_accum #(
    parameter int DW = 16,
    localparam int AW = DW + 1,
    localparam int SW = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          strobe,
    input  logic          clear,
    input  logic [AW-1:0] num_eff,
    input  logic [AW-1:0] den_eff,
    output logic [AW-1:0] acc,
    output logic          tick
);
    logic [SW-1:0] sum;
    logic          hit;
    logic          saturate;
    logic [AW-1:0] acc_next;

    assign sum      = {1'b0, acc} + {1'b0, num_eff};
    assign hit      = sum >= {1'b0, den_eff};
    assign saturate = num_eff >= den_eff;

    always_comb begin
        acc_next = acc;
        if (strobe) begin
            if (!hit)          acc_next = sum[AW-1:0];
            else if (saturate) acc_next = '0;
            else               acc_next = AW'(sum - {1'b0, den_eff});
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc  <= '0;
            tick <= 1'b0;
        end else begin
            tick <= strobe && hit;
            if (!en || clear) acc <= '0;
            else              acc <= acc_next;
        end
    end
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import baud_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          uart_en,
    input  logic          wr_valid,
    input  logic [1:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    output logic          tick
);
    localparam int AW = DW + 1;

    logic [CODE_W-1:0] pre_code;
    logic              pre_load;
    logic              commit;
    logic              armed;
    logic [AW-1:0]     num_eff;
    logic [AW-1:0]     den_eff;
    logic [AW-1:0]     acc;
    logic              strobe;

    baud_cfg #(.DW(DW)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .wr_valid (wr_valid),
        .wr_sel   (reg_sel_e'(wr_sel)),
        .wr_data  (wr_data),
        .pre_code (pre_code),
        .pre_load (pre_load),
        .commit   (commit),
        .armed    (armed),
        .num_eff  (num_eff),
        .den_eff  (den_eff)
    );

    baud_prescale u_pre (
        .clk     (clk),
        .rst     (rst),
        .en      (uart_en),
        .restart (pre_load),
        .code    (pre_code),
        .strobe  (strobe)
    );

    baud_accum #(.DW(DW)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .en      (uart_en),
        .strobe  (strobe),
        .clear   (commit),
        .num_eff (num_eff),
        .den_eff (den_eff),
        .acc     (acc),
        .tick    (tick)
    );
endmodule

// File: rtl/baud_tick_chk.sv
module baud_tick_chk #(
    parameter int DW = 16,
    localparam int AW = DW + 1
) (
    input logic          clk,
    input logic          rst,
    input logic          uart_en,
    input logic          wr_valid,
    input logic [1:0]    wr_sel,
    input logic          tick,
    input logic          strobe,
    input logic          armed,
    input logic [AW-1:0] acc,
    input logic [AW-1:0] num_eff,
    input logic [AW-1:0] den_eff
);
    p_quiet_in_reset_r1: assert property (@(posedge clk)
        rst |=> !tick);

    p_acc_below_den_r3: assert property (@(posedge clk) disable iff (rst)
        acc < den_eff);

    p_tick_needs_strobe_r4: assert property (@(posedge clk) disable iff (rst)
        tick |-> $past(strobe));

    p_lone_num_keeps_rate_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_sel == 2'd1) |=> ($stable(num_eff) && $stable(den_eff)));

    p_commit_clears_acc_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_sel == 2'd2 && armed) |=> (acc == '0));

    p_lone_den_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_sel == 2'd2 && !armed) |=> ($stable(den_eff) && $stable(num_eff)));

    p_tick_gated_r8: assert property (@(posedge clk) disable iff (rst)
        !uart_en |=> !tick);
endmodule

bind baud_tick_gen baud_tick_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .uart_en  (uart_en),
    .wr_valid (wr_valid),
    .wr_sel   (wr_sel),
    .tick     (tick),
    .strobe   (strobe),
    .armed    (armed),
    .acc      (acc),
    .num_eff  (num_eff),
    .den_eff  (den_eff)
);

// File: tb/baud_tick_gen_test.sv
module baud_tick_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          uart_en = 1'b0;
    logic          wr_valid = 1'b0;
    logic [1:0]    wr_sel = 2'd0;
    logic [DW-1:0] wr_data = '0;
    logic          tick;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    int    tick_count = 0;

    // behavioural reference state
    int m_ratio, m_pcnt, m_acc, m_num, m_den, m_shadow;
    bit m_armed, exp_tick;

    baud_tick_gen #(.DW(DW)) uut (
        .clk(clk), .rst(rst), .uart_en(uart_en), .wr_valid(wr_valid),
        .wr_sel(wr_sel), .wr_data(wr_data), .tick(tick)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int ratio_for(int code);
        int table_r[8] = '{6, 5, 4, 3, 2, 1, 7, 1};
        return table_r[code & 7];
    endfunction

    always @(posedge clk) begin
        bit strobe_m, nt;
        int s;
        if (rst) begin
            m_ratio = 1; m_pcnt = 0; m_acc = 0; m_num = 16; m_den = 1;
            m_shadow = 16; m_armed = 0; exp_tick = 0;
        end else begin
            strobe_m = uart_en && (m_pcnt == m_ratio - 1);
            nt = 0;
            if (strobe_m) begin
                s = m_acc + m_num;
                if (s >= m_den) begin
                    nt = 1;
                    m_acc = (m_num >= m_den) ? 0 : s - m_den;
                end else m_acc = s;
            end
            if (!uart_en) begin m_pcnt = 0; m_acc = 0; end
            else m_pcnt = strobe_m ? 0 : m_pcnt + 1;
            if (wr_valid) begin
                case (wr_sel)
                    2'd0: begin m_ratio = ratio_for(int'(wr_data)); m_pcnt = 0; end
                    2'd1: m_shadow = int'(wr_data) + 1;
                    2'd2: if (m_armed) begin
                              m_num = m_shadow; m_den = int'(wr_data) + 1; m_acc = 0;
                          end
                    default: ;
                endcase
                m_armed = (wr_sel == 2'd1);
            end
            exp_tick = nt;
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // one clock: compare at falling edge, then drive the next inputs
    task automatic step(bit v, logic [1:0] s, int d);
        @(negedge clk);
        check(cur_req, int'(tick), int'(exp_tick));
        if (tick) tick_count++;
        wr_valid = v; wr_sel = s; wr_data = DW'(d);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 2'd0, 0);
    endtask

    task automatic count_window(string req, int n, int expect_n);
        int diff;
        tick_count = 0;
        idle(n);
        diff = tick_count - expect_n;
        checks++;
        if (diff > 1 || diff < -1) begin
            errors++;
            $display("FAIL %s tick count actual=%0d expected=%0d", req, tick_count, expect_n);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: quiet in reset, then defaults give a tick every clock
        cur_req = "R1";
        idle(4);
        @(negedge clk); rst = 1'b0; uart_en = 1'b1;
        count_window("R1", 40, 40);

        // R8: enable low gates everything
        cur_req = "R8";
        uart_en = 1'b0;
        count_window("R8", 20, 0);
        uart_en = 1'b1;

        // R2: every prescaler code with num == den (tick per strobe)
        cur_req = "R2";
        step(1, 2'd1, 15); step(1, 2'd2, 15); step(0, 2'd0, 0);
        for (int c = 0; c < 8; c++) begin
            step(1, 2'd0, c);
            count_window("R2", 168, 168 / ratio_for(c));
        end

        // R3: fractional rate, ratio 4, 3/8
        cur_req = "R3";
        step(1, 2'd0, 2); step(1, 2'd1, 2); step(1, 2'd2, 7);
        count_window("R3", 320, 30);
        // R3: ratio 1, 16/(den+1) with den reg 39 -> 2/5
        step(1, 2'd0, 5); step(1, 2'd1, 15); step(1, 2'd2, 39);
        count_window("R3", 200, 80);

        // R4: numerator above denominator clamps to one tick per strobe
        cur_req = "R4";
        step(1, 2'd0, 4); step(1, 2'd1, 99); step(1, 2'd2, 9);
        count_window("R4", 100, 50);

        // R5: lone numerator write leaves rate at 1/2 per clock
        cur_req = "R5";
        step(1, 2'd0, 5); step(1, 2'd1, 0); step(1, 2'd2, 1);
        step(1, 2'd1, 1);
        count_window("R5", 60, 30);

        // R6: commit with idle clocks between the pair -> 1/4
        cur_req = "R6";
        step(1, 2'd1, 0); idle(3); step(1, 2'd2, 3);
        count_window("R6", 80, 20);

        // R7: lone denominator, and pair broken by other writes
        cur_req = "R7";
        step(1, 2'd2, 0);
        count_window("R7", 40, 10);
        step(1, 2'd1, 9); step(1, 2'd3, 0); step(1, 2'd2, 9);
        count_window("R7", 40, 10);
        step(1, 2'd1, 9); step(1, 2'd0, 5); step(1, 2'd2, 9);
        count_window("R7", 40, 10);

        // R8: enable toggling mid-fraction
        cur_req = "R8";
        for (int k = 0; k < 5; k++) begin
            uart_en = 1'b0; idle(3);
            uart_en = 1'b1; idle(7);
        end

        idle(2);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule